// File: doc/BRIEF.md
# Receive Packet Handler with CRC Check and De-whitening

This block follows a detected sync pattern and turns the received byte stream into payload bytes for a receive FIFO. It supports two framing formats. In the fixed format the payload size comes from configuration. In the variable format the first byte carries the size.

Each byte can be de-whitened on the way in, using a 9-bit linear feedback sequence that is restarted for every packet. The first payload byte can be filtered against a node address, or against a node address and a broadcast address. The payload can be closed by a 16-bit CRC, which is checked before the packet is declared good.

Payload bytes go to the FIFO as soon as they arrive. At the end of a packet the block gives one of two verdicts. A one-cycle payload-ready pulse means the packet is good. A one-cycle discard pulse tells the FIFO owner to drop what was written for the packet.

Top module: `rx_pkt_handler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, fifoWr, payloadReady, discard and crcOk are all 0.
- R2: A byte strobed in while no packet is open is ignored: it is not written and it produces neither verdict pulse. A packet opens on syncMatch, and any byte strobed in the same cycle as syncMatch is also ignored.
- R3: With varLen=0, exactly fixedLen bytes after the sync are written to the FIFO. Each byte is written (fifoWr=1) in the cycle after it is strobed in. If crcEn=0, payloadReady pulses in the same cycle as the last write.
- R4: With varLen=1, the first byte is the length L. The length byte is written to the FIFO and is not counted in L, and exactly L more bytes follow it and are written.
- R5: A length byte of 0, or a length byte above maxLen, makes discard pulse in the cycle after that byte. Nothing of the packet is written, and the remaining bytes are ignored. A length equal to maxLen is accepted.
- R6: addrMode selects address filtering. 0 means no filtering. 1 means the first byte after the length must equal nodeAddr. 2 or 3 means it must equal nodeAddr or bcastAddr. On a mismatch that byte is not written, discard pulses and the rest of the packet is ignored.
- R7: With whiteEn=1, every byte of the packet (length, address, payload and CRC bytes) is XORed with bits [7:0] of a 9-bit state s, bit i with bit i. s is set to 0x1FF at sync. After each byte, s is advanced 8 times by s = {s[0]^s[5], s[8:1]}. With whiteEn=0, bytes pass unchanged.
- R8: With crcEn=1, two CRC bytes (high byte first) follow the payload and are not written. The CRC is computed over the de-whitened length, address and payload bytes. The CRC state starts at 0x1D0F. For each bit, MSB first, fb = crc[15]^bit, then crc = crc<<1, and crc is XORed with 0x1021 when fb is 1. If the received value equals the complement of the final state, payloadReady pulses and crcOk becomes 1; otherwise discard pulses and crcOk is 0.
- R9: crcOk goes to 0 in the cycle after syncMatch. It stays 0 for packets received with crcEn=0, and otherwise holds its value until the next sync.
- R10: Each packet that opens ends with exactly one one-cycle pulse, either payloadReady or discard, and the two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| syncMatch | input | 1 | Opens a new packet; restarts de-whitening and CRC |
| byteValid | input | 1 | byteIn carries a received byte this cycle |
| byteIn | input | 8 | Received (possibly whitened) byte |
| varLen | input | 1 | 1: variable format with length byte; 0: fixed format |
| fixedLen | input | 8 | Payload byte count in the fixed format |
| maxLen | input | 8 | Largest accepted length byte |
| nodeAddr | input | 8 | Node address for filtering |
| bcastAddr | input | 8 | Broadcast address for filtering |
| addrMode | input | 2 | 0 none, 1 node only, 2/3 node or broadcast |
| whiteEn | input | 1 | Enables de-whitening |
| crcEn | input | 1 | Enables the trailing CRC check |
| fifoData | output | 8 | De-whitened byte for the FIFO |
| fifoWr | output | 1 | Write strobe for fifoData |
| payloadReady | output | 1 | One-cycle pulse: packet complete and accepted |
| crcOk | output | 1 | CRC of the last checked packet matched |
| discard | output | 1 | One-cycle pulse: packet rejected, drop its FIFO bytes |

## Verification
The main function is tried with fixed and variable framings, with de-whitening and CRC both on and off, and with addresses that hit the node, hit the broadcast value, or miss. A packet with one flipped CRC bit separates a correct CRC comparison from one that always passes. Length bytes of 0, maxLen and maxLen+1 locate the boundary of the length check exactly. Whitened packets with a CRC only decode if the sequence covers every byte, including the length and CRC bytes. A run of randomly configured packets, checked against bench models of the sequence and the CRC, covers the combinations that the directed cases leave out.

// File: rtl/rxph_pkg.sv
`timescale 1ns/1ps
package rxph_pkg;
  localparam int BYTE_W = 8;
  localparam int LFSR_W = 9;
  localparam int CRC_W  = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 9'h1FF;
  localparam logic [CRC_W-1:0]  CRC_SEED  = 16'h1D0F;
  localparam logic [CRC_W-1:0]  CRC_POLY  = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEN, ST_PAY, ST_CRCH, ST_CRCL
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic seed;      // restart sequence and CRC
    logic step;      // advance whitening sequence by one byte
    logic crcUpd;    // fold current plain byte into CRC
    logic crcHiCap;  // hold received CRC high byte
  } dpOps_t;
endpackage

// File: rtl/rxph_dpath.sv
`timescale 1ns/1ps
module rxph_dpath
  import rxph_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpOps_t            ops,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              whiteEn,
  input  logic [BYTE_W-1:0] nodeAddr,
  input  logic [BYTE_W-1:0] bcastAddr,
  input  logic [1:0]        addrMode,
  output logic [BYTE_W-1:0] plainByte,
  output logic              addrHit,
  output logic              crcMatch
);
  logic [LFSR_W-1:0] lfsr;
  logic [CRC_W-1:0]  crcReg;
  logic [BYTE_W-1:0] crcHi;

  function automatic logic [LFSR_W-1:0] lfsrAdvance(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] t;
    t = s;
    for (int i = 0; i < BYTE_W; i++) t = {t[0] ^ t[5], t[LFSR_W-1:1]};
    return t;
  endfunction

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] t;
    logic fb;
    t = c;
    for (int i = BYTE_W-1; i >= 0; i--) begin
      fb = t[CRC_W-1] ^ d[i];
      t  = {t[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return t;
  endfunction

  assign plainByte = whiteEn ? (byteIn ^ lfsr[BYTE_W-1:0]) : byteIn;
  assign addrHit   = (plainByte == nodeAddr) || (addrMode[1] && (plainByte == bcastAddr));
  assign crcMatch  = ({crcHi, plainByte} == ~crcReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsr   <= LFSR_SEED;
      crcReg <= CRC_SEED;
      crcHi  <= '0;
    end else if (ops.seed) begin
      lfsr   <= LFSR_SEED;
      crcReg <= CRC_SEED;
    end else begin
      if (ops.step)     lfsr   <= lfsrAdvance(lfsr);
      if (ops.crcUpd)   crcReg <= crcByte(crcReg, plainByte);
      if (ops.crcHiCap) crcHi  <= plainByte;
    end
  end

  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN) lfsr != '0);
  // R7
  crc_step_chk: assert property (@(posedge clk) disable iff (!rstN) ops.crcUpd |-> ops.step);
endmodule

// File: rtl/rxph_ctrl.sv
`timescale 1ns/1ps
module rxph_ctrl
  import rxph_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMatch,
  input  logic              byteValid,
  input  logic              varLen,
  input  logic [BYTE_W-1:0] fixedLen,
  input  logic [BYTE_W-1:0] maxLen,
  input  logic [1:0]        addrMode,
  input  logic              crcEn,
  input  logic [BYTE_W-1:0] plainByte,
  input  logic              addrHit,
  input  logic              crcMatch,
  output dpOps_t            ops,
  output logic [BYTE_W-1:0] fifoData,
  output logic              fifoWr,
  output logic              payloadReady,
  output logic              discard,
  output logic              crcOk
);
  rxState_t          state;
  logic [BYTE_W-1:0] remain;
  logic              firstByte;
  logic              take;

  assign take = byteValid && !syncMatch && (state != ST_IDLE);

  always_comb begin
    ops.seed     = syncMatch;
    ops.step     = take;
    ops.crcUpd   = take && ((state == ST_LEN) || (state == ST_PAY));
    ops.crcHiCap = take && (state == ST_CRCH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      remain       <= '0;
      firstByte    <= 1'b0;
      fifoData     <= '0;
      fifoWr       <= 1'b0;
      payloadReady <= 1'b0;
      discard      <= 1'b0;
      crcOk        <= 1'b0;
    end else begin
      fifoWr       <= 1'b0;
      payloadReady <= 1'b0;
      discard      <= 1'b0;
      if (syncMatch) begin
        state     <= varLen ? ST_LEN : ST_PAY;
        remain    <= fixedLen;
        firstByte <= 1'b1;
        crcOk     <= 1'b0;
      end else if (take) begin
        case (state)
          ST_LEN: begin
            if ((plainByte == '0) || (plainByte > maxLen)) begin
              discard <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              fifoWr   <= 1'b1;
              fifoData <= plainByte;
              remain   <= plainByte;
              state    <= ST_PAY;
            end
          end
          ST_PAY: begin
            if (firstByte && (addrMode != 2'd0) && !addrHit) begin
              discard <= 1'b1;
              state   <= ST_IDLE;
            end else begin
              fifoWr    <= 1'b1;
              fifoData  <= plainByte;
              firstByte <= 1'b0;
              remain    <= remain - 1'b1;
              if (remain == 8'd1) begin
                if (crcEn) state <= ST_CRCH;
                else begin
                  payloadReady <= 1'b1;
                  state        <= ST_IDLE;
                end
              end
            end
          end
          ST_CRCH: state <= ST_CRCL;
          ST_CRCL: begin
            if (crcMatch) begin
              payloadReady <= 1'b1;
              crcOk        <= 1'b1;
            end else begin
              discard <= 1'b1;
            end
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R10
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(payloadReady && discard));
  // R10
  verdict_closes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (payloadReady || discard) |=> !(fifoWr || payloadReady || discard));
  // R2
  write_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoWr |-> ($past(byteValid) && !$past(syncMatch)));
  // R9
  crcok_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(crcOk) |-> payloadReady);
  // R9
  crcok_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncMatch |=> !crcOk);
endmodule

// File: rtl/rx_pkt_handler.sv
`timescale 1ns/1ps
module rx_pkt_handler
  import rxph_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncMatch,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              varLen,
  input  logic [BYTE_W-1:0] fixedLen,
  input  logic [BYTE_W-1:0] maxLen,
  input  logic [BYTE_W-1:0] nodeAddr,
  input  logic [BYTE_W-1:0] bcastAddr,
  input  logic [1:0]        addrMode,
  input  logic              whiteEn,
  input  logic              crcEn,
  output logic [BYTE_W-1:0] fifoData,
  output logic              fifoWr,
  output logic              payloadReady,
  output logic              crcOk,
  output logic              discard
);
  dpOps_t            ops;
  logic [BYTE_W-1:0] plainByte;
  logic              addrHit;
  logic              crcMatch;

  rxph_dpath uDpath (
    .clk(clk), .rstN(rstN), .ops(ops), .byteIn(byteIn), .whiteEn(whiteEn),
    .nodeAddr(nodeAddr), .bcastAddr(bcastAddr), .addrMode(addrMode),
    .plainByte(plainByte), .addrHit(addrHit), .crcMatch(crcMatch)
  );

  rxph_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .syncMatch(syncMatch), .byteValid(byteValid),
    .varLen(varLen), .fixedLen(fixedLen), .maxLen(maxLen), .addrMode(addrMode),
    .crcEn(crcEn), .plainByte(plainByte), .addrHit(addrHit), .crcMatch(crcMatch),
    .ops(ops), .fifoData(fifoData), .fifoWr(fifoWr), .payloadReady(payloadReady),
    .discard(discard), .crcOk(crcOk)
  );
endmodule

// File: tb/tb_rx_pkt_handler.sv
`timescale 1ns/1ps
module tb_rx_pkt_handler;
  typedef logic [7:0] u8;
  typedef u8 u8q[$];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic syncMatch = 1'b0, byteValid = 1'b0;
  u8    byteIn = '0;
  logic varLen = 1'b0;
  u8    fixedLen = 8'd4, maxLen = 8'd32, nodeAddr = 8'h5A, bcastAddr = 8'hFF;
  logic [1:0] addrMode = 2'd0;
  logic whiteEn = 1'b0, crcEn = 1'b0;
  u8    fifoData;
  logic fifoWr, payloadReady, crcOk, discard;

  int nChk = 0, nFail = 0;
  bit done = 0;
  u8  got[$];
  int prCnt = 0, dcCnt = 0;

  always #2.5 clk = ~clk;

  rx_pkt_handler dut (
    .clk(clk), .rstN(rstN), .syncMatch(syncMatch), .byteValid(byteValid),
    .byteIn(byteIn), .varLen(varLen), .fixedLen(fixedLen), .maxLen(maxLen),
    .nodeAddr(nodeAddr), .bcastAddr(bcastAddr), .addrMode(addrMode),
    .whiteEn(whiteEn), .crcEn(crcEn), .fifoData(fifoData), .fifoWr(fifoWr),
    .payloadReady(payloadReady), .crcOk(crcOk), .discard(discard)
  );

  always @(posedge clk) begin
    #1;
    if (fifoWr) got.push_back(fifoData);
    if (payloadReady) prCnt++;
    if (discard) dcCnt++;
  end

  task automatic chk(input bit ok, input string msg);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic u8q whiten(input u8q q);
    logic [8:0] s;
    u8q r;
    s = 9'h1FF;
    r = q;
    for (int i = 0; i < r.size(); i++) begin
      r[i] = r[i] ^ s[7:0];
      for (int k = 0; k < 8; k++) s = {s[0] ^ s[5], s[8:1]};
    end
    return r;
  endfunction

  function automatic logic [15:0] crcOf(input u8q q);
    logic [15:0] c;
    logic fb;
    c = 16'h1D0F;
    for (int i = 0; i < q.size(); i++)
      for (int b = 7; b >= 0; b--) begin
        fb = c[15] ^ q[i][b];
        c  = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic sendWire(input u8q w);
    got.delete(); prCnt = 0; dcCnt = 0;
    @(negedge clk); syncMatch = 1'b1; byteValid = 1'b0;
    @(negedge clk); syncMatch = 1'b0;
    for (int i = 0; i < w.size(); i++) begin
      byteIn = w[i]; byteValid = 1'b1;
      @(negedge clk);
    end
    byteValid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // plain: de-whitened frame content; nWr: bytes of plain expected in the FIFO
  task automatic runCase(input string tag, input u8q plain, input bit corrupt,
                         input int nWr, input int ePr, input int eDc, input bit eOk);
    u8q w;
    logic [15:0] c;
    bit same;
    w = plain;
    if (crcEn) begin
      c = ~crcOf(plain);
      w.push_back(c[15:8]);
      w.push_back(c[7:0]);
    end
    if (corrupt) w[w.size()-1] = w[w.size()-1] ^ 8'h01;
    if (whiteEn) w = whiten(w);
    sendWire(w);
    chk(got.size() == nWr, $sformatf("%s writes act=%0d exp=%0d", tag, got.size(), nWr));
    same = (got.size() == nWr);
    for (int i = 0; i < nWr && same; i++) same = (got[i] == plain[i]);
    chk(same, $sformatf("%s fifo bytes act=%p exp=%p", tag, got, plain));
    chk(prCnt == ePr && dcCnt == eDc,
        $sformatf("%s R10 verdict act=%0d/%0d exp=%0d/%0d", tag, prCnt, dcCnt, ePr, eDc));
    chk(crcOk == eOk, $sformatf("%s crcOk act=%0d exp=%0d", tag, crcOk, eOk));
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    u8q p;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!fifoWr && !payloadReady && !discard && !crcOk,
        $sformatf("R1 in reset act=%b%b%b%b exp=0000", fifoWr, payloadReady, discard, crcOk));
    rstN = 1'b1;
    #3;
    chk(!fifoWr && !payloadReady && !discard && !crcOk,
        $sformatf("R1 after reset act=%b%b%b%b exp=0000", fifoWr, payloadReady, discard, crcOk));

    // R2: bytes with no packet open
    got.delete(); prCnt = 0; dcCnt = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); byteIn = u8'(8'h30 + i); byteValid = 1'b1;
    end
    @(negedge clk); byteValid = 1'b0;
    repeat (2) @(negedge clk);
    chk(got.size() == 0 && prCnt == 0 && dcCnt == 0,
        $sformatf("R2 idle bytes act=%0d writes exp=0", got.size()));

    // R3 fixed, plain
    varLen = 0; fixedLen = 4; addrMode = 0; whiteEn = 0; crcEn = 0;
    p = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    runCase("R3 fixed", p, 0, 4, 1, 0, 0);

    // R4 R7 R8 variable, whitened, crc
    varLen = 1; whiteEn = 1; crcEn = 1; maxLen = 32;
    p = '{8'd5, 8'hA1, 8'h00, 8'hFF, 8'h3C, 8'h7E};
    runCase("R4 R7 R8 var white crc", p, 0, 6, 1, 0, 1);
    runCase("R8 bad crc", p, 1, 6, 0, 1, 0);

    // R8 crc without whitening
    whiteEn = 0;
    p = '{8'd2, 8'h00, 8'h00};
    runCase("R8 crc zeros", p, 0, 3, 1, 0, 1);

    // R9 clear at sync
    @(negedge clk); syncMatch = 1'b1;
    @(negedge clk); syncMatch = 1'b0;
    #3;
    chk(!crcOk, $sformatf("R9 crcOk after sync act=%0d exp=0", crcOk));

    // R5 length boundaries
    crcEn = 0; maxLen = 10;
    p = '{8'd0, 8'h12, 8'h34};
    runCase("R5 len zero", p, 0, 0, 0, 1, 0);
    p = '{8'd11};
    for (int i = 0; i < 11; i++) p.push_back(u8'(i));
    runCase("R5 len over max", p, 0, 0, 0, 1, 0);
    p = '{8'd10};
    for (int i = 0; i < 10; i++) p.push_back(u8'(8'h40 + i));
    runCase("R5 len at max", p, 0, 11, 1, 0, 0);

    // R6 address filtering, fixed length 3
    varLen = 0; fixedLen = 3; nodeAddr = 8'h5A; bcastAddr = 8'hFF; whiteEn = 1;
    addrMode = 1;
    p = '{8'h5A, 8'h01, 8'h02};
    runCase("R6 node hit", p, 0, 3, 1, 0, 0);
    p = '{8'hFF, 8'h01, 8'h02};
    runCase("R6 bcast in node mode", p, 0, 0, 0, 1, 0);
    addrMode = 2;
    runCase("R6 bcast hit", p, 0, 3, 1, 0, 0);
    p = '{8'h5B, 8'h01, 8'h02};
    runCase("R6 miss", p, 0, 0, 0, 1, 0);

    // random packets, all expected good
    for (int n = 0; n < 40; n++) begin
      int len;
      varLen = 1'($urandom);
      whiteEn = 1'($urandom);
      crcEn = 1'($urandom);
      addrMode = 2'($urandom_range(0, 2));
      maxLen = 8'd32;
      nodeAddr = u8'($urandom);
      bcastAddr = u8'($urandom);
      len = $urandom_range(1, 20);
      fixedLen = u8'(len);
      p.delete();
      if (varLen) p.push_back(u8'(len));
      for (int i = 0; i < len; i++) p.push_back(u8'($urandom));
      if (addrMode != 0) p[varLen ? 1 : 0] = (addrMode == 2 && $urandom_range(0, 1)) ? bcastAddr : nodeAddr;
      runCase($sformatf("R3 R4 R6 R7 R8 R9 random %0d", n), p, 0, p.size(), 1, 0, crcEn);
    end

    done = 1;
    finishRun();
  end
endmodule